// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. Each cycle it takes an operation code, the accumulator value, a second operand, and the current carry and half-carry flags. One clock later it presents the result byte, new carry, half-carry and overflow values, and one write enable for each flag. The surrounding flag register updates a flag only when that flag's enable is high. A flag whose enable is low is left alone.

The operation set has three parts. The first is binary addition, with or without the incoming carry. The second is a set of flag-neutral byte operations: AND, clear, one's complement, increment and decrement. The third is a decimal correction step, which turns the binary sum of two packed-BCD bytes into a packed-BCD result. This step may set the carry but never clears it.

Top module: `acc_alu8`

## Requirements
- R1: Inputs are registered, and all outputs appear one clock after the inputs are sampled. A synchronous active-high reset drives every output to zero. The op field is encoded as follows: 0 add, 1 add with carry, 2 AND, 3 clear, 4 complement, 5 increment, 6 decrement, 7 decimal adjust.
- R2: Add (op 0) ignores `c_i`. It gives (acc+opnd) mod 256. `c_o` is the carry out of bit 7 and `ac_o` is the carry out of bit 3. All three flag enables are high.
- R3: For add and add with carry, `ov_o` is set exactly when one, but not both, of the carry out of bit 6 and the carry out of bit 7 occurs.
- R4: Add with carry (op 1) includes `c_i` in the sum and in every flag, using the rules of R2 and R3. For example, 0xC3+0xAA+1 gives 0x6E with C=1, AC=0 and OV=1.
- R5: Decimal adjust (op 7), first step: 6 is added to the whole byte when the low nibble of acc is above 9 or `ac_i` is 1.
- R6: Decimal adjust, second step: 0x60 is added when the high nibble after the first step is above 9, or `c_i` is 1, or the first step carried out of bit 7. `c_o` is `c_i` OR'd with both step carries, so the carry is never cleared. Only the C enable is high. For example, 0xBE with C=0 and AC=0 gives 0x24 with C=1.
- R7: Increment (op 5) wraps 0xFF to 0x00. Decrement (op 6) wraps 0x00 to 0xFF. All flag enables are low.
- R8: AND (op 2) gives acc&opnd, clear (op 3) gives 0x00, and complement (op 4) gives ~acc. All flag enables are low.
- R9: Whenever a flag's enable is low, `c_o` echoes `c_i`, `ac_o` echoes `ac_i`, and `ov_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (see R1) |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| c_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming half-carry flag |
| res_o | output | 8 | Result byte |
| c_o | output | 1 | Carry flag value |
| ac_o | output | 1 | Half-carry flag value |
| ov_o | output | 1 | Overflow flag value |
| we_c_o | output | 1 | Carry write enable |
| we_ac_o | output | 1 | Half-carry write enable |
| we_ov_o | output | 1 | Overflow write enable |

## Verification
The hardest path to reach is the one where the decimal adjust's first step carries out of bit 7. This happens only for accumulator values 0xFA to 0xFF with the low correction active. In that case the carry by itself must force the high correction, even though the high nibble is then small. A second case is a preset carry with no new carry, where C must stay set.

The bench sweeps all 256 accumulator values against all four combinations of the incoming carry and half-carry, so both cases occur with every neighbouring value. Add and add-with-carry are swept over all 65,536 operand pairs, with the incoming carry derived from operand bits so that both values appear throughout the space.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_AND  = 3'd2,
    OP_CLR  = 3'd3,
    OP_CPL  = 3'd4,
    OP_INC  = 3'd5,
    OP_DEC  = 3'd6,
    OP_DADJ = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic ac;
    logic ov;
  } flag3_t;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int unsigned H = W / 2;

  logic [W:0]   full_s;
  logic [W-1:0] low_s;   // sum of the low W-1 bits, MSB = carry into top bit
  logic [H:0]   nib_s;

  assign full_s = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign low_s  = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
  assign nib_s  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};

  assign sum_o = full_s[W-1:0];
  assign c_o   = full_s[W];
  assign ac_o  = nib_s[H];
  assign ov_o  = full_s[W] ^ low_s[W-1];
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int unsigned H = W / 2;
  localparam logic [H-1:0]  NIB_MAX = H'(9);
  localparam logic [W:0]    LO_ADJ  = (W+1)'(6);
  localparam logic [W:0]    HI_ADJ  = (W+1)'(6) << H;

  logic       lo_fix, hi_fix;
  logic [W:0] step1, step2;

  always_comb begin
    lo_fix = (a_i[H-1:0] > NIB_MAX) || ac_i;
    step1  = {1'b0, a_i} + (lo_fix ? LO_ADJ : '0);
    hi_fix = (step1[W-1:H] > NIB_MAX) || c_i || step1[W];
    step2  = {1'b0, step1[W-1:0]} + (hi_fix ? HI_ADJ : '0);
  end

  assign res_o = step2[W-1:0];
  assign c_o   = c_i | step1[W] | step2[W];
endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_CLR:  res_o = '0;
      OP_CPL:  res_o = ~a_i;
      OP_INC:  res_o = a_i + W'(1);
      OP_DEC:  res_o = a_i - W'(1);
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         c_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         ac_o,
  output logic         ov_o,
  output logic         we_c_o,
  output logic         we_ac_o,
  output logic         we_ov_o
);
  alu_op_e      op_e;
  logic [W-1:0] add_sum, da_res, un_res, res_n;
  logic         add_c, add_ac, add_ov, add_cin, da_c;
  flag3_t       flg_n, we_n;

  assign op_e    = alu_op_e'(op_i);
  assign add_cin = (op_e == OP_ADDC) && c_i;

  acc_alu_adder #(.W(W)) adder_i (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(add_cin),
    .sum_o(add_sum), .c_o(add_c), .ac_o(add_ac), .ov_o(add_ov)
  );

  acc_alu_decadj #(.W(W)) decadj_i (
    .a_i(acc_i), .c_i(c_i), .ac_i(ac_i), .res_o(da_res), .c_o(da_c)
  );

  acc_alu_unary #(.W(W)) unary_i (
    .op_i(op_e), .a_i(acc_i), .b_i(opnd_i), .res_o(un_res)
  );

  always_comb begin
    flg_n = '{c: c_i, ac: ac_i, ov: 1'b0};
    we_n  = '0;
    res_n = un_res;
    unique case (op_e)
      OP_ADD, OP_ADDC: begin
        res_n = add_sum;
        flg_n = '{c: add_c, ac: add_ac, ov: add_ov};
        we_n  = '{c: 1'b1, ac: 1'b1, ov: 1'b1};
      end
      OP_DADJ: begin
        res_n   = da_res;
        flg_n.c = da_c;
        we_n.c  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      c_o     <= 1'b0;
      ac_o    <= 1'b0;
      ov_o    <= 1'b0;
      we_c_o  <= 1'b0;
      we_ac_o <= 1'b0;
      we_ov_o <= 1'b0;
    end else begin
      res_o   <= res_n;
      c_o     <= flg_n.c;
      ac_o    <= flg_n.ac;
      ov_o    <= flg_n.ov;
      we_c_o  <= we_n.c;
      we_ac_o <= we_n.ac;
      we_ov_o <= we_n.ov;
    end
  end

  AST_ADD_WRITES_ALL: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd0 || op_i == 3'd1) |=> (we_c_o && we_ac_o && we_ov_o)); // R2
  AST_BYTE_OPS_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 3'd2 && op_i <= 3'd6) |=> (!we_c_o && !we_ac_o && !we_ov_o)); // R8
  AST_DA_C_STICKY: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd7 && c_i) |=> c_o); // R6
  AST_DA_ONLY_C: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd7) |=> (we_c_o && !we_ac_o && !we_ov_o)); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd3) |=> (res_o == '0)); // R8
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd5 && acc_i == '1) |=> (res_o == '0)); // R7
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd6 && acc_i == '0) |=> (res_o == '1)); // R7
  AST_KEEP_C: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 3'd2 && op_i <= 3'd6) |=> (c_o == $past(c_i) && !ov_o)); // R9
endmodule

// File: tb/acc_alu8_tb.sv
module acc_alu8_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op = '0;
  logic [7:0] acc = '0, opnd = '0;
  logic       ci = 1'b0, aci = 1'b0;
  logic [7:0] res;
  logic       co, aco, ovo, wec, weac, weov;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  acc_alu8 #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .c_i(ci), .ac_i(aci), .res_o(res), .c_o(co), .ac_o(aco), .ov_o(ovo),
    .we_c_o(wec), .we_ac_o(weac), .we_ov_o(weov)
  );

  task automatic compare(input string tag, input logic [7:0] er, input logic ec, eac, eov,
                         input logic wc, wac, wov);
    n_run++;
    if (res !== er || co !== ec || aco !== eac || ovo !== eov ||
        wec !== wc || weac !== wac || weov !== wov) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b ac=%b got res=%h c=%b ac=%b ov=%b we=%b%b%b exp res=%h c=%b ac=%b ov=%b we=%b%b%b",
               tag, op, acc, opnd, ci, aci, res, co, aco, ovo, wec, weac, weov,
               er, ec, eac, eov, wc, wac, wov);
    end
  endtask

  // Drive one operation, wait for the registered result, check against the model.
  task automatic run(input string tag, input int o, input int a, input int b,
                     input bit c, input bit h);
    int       s, lo, lo7, adj, v;
    logic [7:0] er;
    logic     ec, eac, eov, wc, wac, wov;
    @(negedge clk);
    op = 3'(o); acc = 8'(a); opnd = 8'(b); ci = c; aci = h;
    @(posedge clk); #1;
    ec = c; eac = h; eov = 1'b0; wc = 1'b0; wac = 1'b0; wov = 1'b0;
    case (o)
      0, 1: begin
        s   = a + b + ((o == 1) ? int'(c) : 0);
        lo  = (a % 16) + (b % 16) + ((o == 1) ? int'(c) : 0);
        lo7 = (a % 128) + (b % 128) + ((o == 1) ? int'(c) : 0);
        er  = 8'(s % 256);
        ec  = (s > 255); eac = (lo > 15); eov = (lo7 > 127) != (s > 255);
        wc = 1'b1; wac = 1'b1; wov = 1'b1;
      end
      2: er = 8'(a & b);
      3: er = 8'h00;
      4: er = 8'(255 - a);
      5: er = 8'((a + 1) % 256);
      6: er = 8'((a + 255) % 256);
      default: begin
        adj = ((a % 16) > 9 || h) ? 6 : 0;
        v   = a + adj;
        if (v > 255) ec = 1'b1;
        v   = v % 256;
        if ((v / 16) > 9 || ec) v = v + 96;
        if (v > 255) ec = 1'b1;
        er  = 8'(v % 256);
        wc  = 1'b1;
      end
    endcase
    compare(tag, er, ec, eac, eov, wc, wac, wov);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op = 3'd1; acc = 8'hFF; opnd = 8'hFF; ci = 1'b1; aci = 1'b1;
    repeat (3) @(posedge clk); #1;
    compare("R1 reset", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    // Worked cases
    run("R4 example", 1, 8'hC3, 8'hAA, 1'b1, 1'b0);
    run("R3 example", 0, 8'hC3, 8'hAA, 1'b1, 1'b1);
    run("R4 bcd-sum", 1, 8'h56, 8'h67, 1'b1, 1'b0);
    run("R6 example", 7, 8'hBE, 8'h00, 1'b0, 1'b0);
    run("R5 inc-bcd", 7, 8'hC9, 8'h00, 1'b1, 1'b0);

    // Reset in mid stream
    @(negedge clk); rst = 1'b1; op = 3'd0; acc = 8'hFF; opnd = 8'h01;
    @(posedge clk); #1;
    compare("R1 mid-reset", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    // Add: incoming carry must be ignored
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run("R2/R3 add", 0, a, b, bit'((a ^ b) & 1), bit'(a[1]));
    // Add with carry over all pairs
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run("R4/R3 addc", 1, a, b, bit'(((a >> 1) ^ b) & 1), bit'(b[2]));
    // Decimal adjust over every accumulator and flag pair
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++)
        run("R5/R6 dadj", 7, a, 255 - a, bit'(f[1]), bit'(f[0]));
    // AND
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 17)
        run("R8/R9 and", 2, a, b, bit'(a[0]), bit'(b[0]));
    // Clear, complement, increment, decrement
    for (int a = 0; a < 256; a++) begin
      run("R8/R9 clr", 3, a, a ^ 8'h5A, bit'(a[1]), bit'(a[2]));
      run("R8/R9 cpl", 4, a, 0, bit'(a[3]), bit'(a[0]));
      run("R7/R9 inc", 5, a, 8'h33, bit'(a[0]), bit'(a[3]));
      run("R7/R9 dec", 6, a, 8'hCC, bit'(a[2]), bit'(a[1]));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule